// File: doc/BRIEF.md
# Branch Condition and Target Unit

This block resolves conditional branches for a 32-bit processor. Each cycle the decode stage may present one branch: a 4-bit condition index, the current zero, carry, negative and overflow flags, the address of the word that follows the branch's immediate, and the signed 32-bit offset taken from that immediate. The unit checks the selected condition against the flags. When the condition holds it returns the sum of the following address and the offset. When it does not hold it returns the following address unchanged.

The result is registered and appears one clock after the request, together with a valid strobe and a taken strobe. Fetch uses the taken strobe to flush and redirect. Carry means "no borrow", so the unsigned comparisons read a set carry as "higher or same". Both unsigned and signed comparisons are provided. Every condition is evaluated in parallel, and the index picks one of the results.

Top module: `br_resolve_unit`

## Requirements
- R1: While `rst_n` is low, and until the first accepted request, `out_valid`, `out_taken` and `out_pc` are all zero.
- R2: Indices 0 through 7 test a single flag, in this order: Z set, Z clear, C set, C clear, N set, N clear, V set, V clear.
- R3: Index 8 is taken when C is set and Z is clear. Index 9 is taken when C is clear or Z is set.
- R4: Index 10 is taken when N equals V. Index 11 is taken when N differs from V.
- R5: Index 12 is taken when Z is clear and N equals V. Index 13 is taken when Z is set or N differs from V.
- R6: Index 14 is always taken, whatever the flags are.
- R7: Index 15 is reserved. It is never taken, and its result address is the following address.
- R8: For a taken branch, `out_pc` equals `in_next_pc + in_offset` modulo 2^32. The offset is treated as two's complement, so a negative offset moves backward and a sum past the top of the address space wraps.
- R9: For a branch that is not taken, `out_pc` equals `in_next_pc`.
- R10: A request sampled at a rising edge sets `out_valid` and gives its result after that edge. A cycle without a request gives `out_valid` and `out_taken` low on the next cycle, with `out_pc` held. `out_taken` is never high without `out_valid`.
- R11: Requests on consecutive cycles each produce their own result, in order, with no gap cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A branch request is present this cycle |
| in_index | input | 4 | Condition index, 0 to 15 |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag (set means no borrow) |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Signed overflow flag |
| in_next_pc | input | 32 | Address following the branch immediate |
| in_offset | input | 32 | Signed branch displacement |
| out_valid | output | 1 | Result of the previous cycle's request |
| out_taken | output | 1 | Branch taken; fetch must redirect |
| out_pc | output | 32 | Target if taken, otherwise the following address |

## Verification
Two functions can fall in the same cycle: the condition decision, and a target sum that wraps past 2^32 or moves backward through a negative offset. Both choose what lands on `out_pc`. The bench provokes this by placing `in_next_pc` near the top of the address space with a positive offset under an always-taken index, and a condition that holds with a negative offset. It then judges that the exact modular sum appears together with the taken strobe. The same wrapping inputs, sent under a condition that fails, must return the unmodified following address. The main sweep also sends all 256 pairs of index and flag pattern back to back. Each pair's result is checked against an independently computed expectation while the next request is already being sampled.

// File: rtl/br_pkg.sv
package br_pkg;

    localparam int unsigned IDX_W    = 4;
    localparam int unsigned NUM_COND = 1 << IDX_W;

    typedef enum logic [IDX_W-1:0] {
        BR_ZSET   = 4'd0,
        BR_ZCLR   = 4'd1,
        BR_CSET   = 4'd2,
        BR_CCLR   = 4'd3,
        BR_NSET   = 4'd4,
        BR_NCLR   = 4'd5,
        BR_VSET   = 4'd6,
        BR_VCLR   = 4'd7,
        BR_UHI    = 4'd8,
        BR_ULS    = 4'd9,
        BR_SGE    = 4'd10,
        BR_SLT    = 4'd11,
        BR_SGT    = 4'd12,
        BR_SLE    = 4'd13,
        BR_ALWAYS = 4'd14,
        BR_RSVD   = 4'd15
    } br_cond_e;

    typedef struct packed {
        logic z;
        logic c;
        logic n;
        logic v;
    } br_flags_t;

    function automatic logic br_cond_holds(input br_cond_e sel, input br_flags_t f);
        logic r;
        case (sel)
            BR_ZSET:   r = f.z;
            BR_ZCLR:   r = !f.z;
            BR_CSET:   r = f.c;
            BR_CCLR:   r = !f.c;
            BR_NSET:   r = f.n;
            BR_NCLR:   r = !f.n;
            BR_VSET:   r = f.v;
            BR_VCLR:   r = !f.v;
            BR_UHI:    r = f.c && !f.z;
            BR_ULS:    r = !f.c || f.z;
            BR_SGE:    r = (f.n == f.v);
            BR_SLT:    r = (f.n != f.v);
            BR_SGT:    r = !f.z && (f.n == f.v);
            BR_SLE:    r = f.z || (f.n != f.v);
            BR_ALWAYS: r = 1'b1;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval
    import br_pkg::*;
(
    input  logic [IDX_W-1:0] sel,
    input  br_flags_t        flags,
    output logic             hit
);

    logic [NUM_COND-1:0] cond_vec;

    for (genvar gi = 0; gi < NUM_COND; gi++) begin : g_cond
        always_comb begin
            cond_vec[gi] = br_cond_holds(br_cond_e'(gi), flags);
        end
    end

    // R2..R5: each even/odd pair below index 14 is a condition and its inverse
    for (genvar gp = 0; gp < 14; gp += 2) begin : g_pair_chk
        always_comb begin
            assert_pair_complement_R5: assert (cond_vec[gp] != cond_vec[gp+1]);
        end
    end

    always_comb begin
        assert_rsvd_never_R7: assert (!cond_vec[NUM_COND-1]);
    end

    assign hit = cond_vec[sel];

endmodule

// File: rtl/br_target_add.sv
module br_target_add #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] disp,
    input  logic              take,
    output logic [ADDR_W-1:0] dest
);

    logic [ADDR_W-1:0] sum;

    always_comb begin
        sum  = base + disp;
        dest = take ? sum : base;
    end

endmodule

// File: rtl/br_resolve_unit.sv
module br_resolve_unit
    import br_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [IDX_W-1:0]  in_index,
    input  logic              flag_z,
    input  logic              flag_c,
    input  logic              flag_n,
    input  logic              flag_v,
    input  logic [ADDR_W-1:0] in_next_pc,
    input  logic [ADDR_W-1:0] in_offset,
    output logic              out_valid,
    output logic              out_taken,
    output logic [ADDR_W-1:0] out_pc
);

    typedef struct packed {
        logic              valid;
        logic              taken;
        logic [ADDR_W-1:0] pc;
    } res_t;

    br_flags_t         flags;
    logic              cond_hit;
    logic [ADDR_W-1:0] dest_pc;
    res_t              res_d, res_q;

    assign flags = '{z: flag_z, c: flag_c, n: flag_n, v: flag_v};

    br_cond_eval u_cond (
        .sel   (in_index),
        .flags (flags),
        .hit   (cond_hit)
    );

    br_target_add #(.ADDR_W(ADDR_W)) u_add (
        .base (in_next_pc),
        .disp (in_offset),
        .take (cond_hit),
        .dest (dest_pc)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = in_valid;
        res_d.taken = in_valid && cond_hit;
        if (in_valid) begin
            res_d.pc = dest_pc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.valid;
    assign out_taken = res_q.taken;
    assign out_pc    = res_q.pc;

    assert_taken_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_taken |-> out_valid);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_taken && $stable(out_pc)));

    assert_request_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_always_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_index == 4'd14) |=>
            (out_taken && out_pc == $past(in_next_pc) + $past(in_offset)));

    assert_reserved_seq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_index == 4'd15) |=>
            (!out_taken && out_pc == $past(in_next_pc)));

    assert_not_taken_seq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_taken) |-> (out_pc == $past(in_next_pc)));

endmodule

// File: tb/br_resolve_unit_bench.sv
module br_resolve_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_index = '0;
    logic        flag_z = 1'b0, flag_c = 1'b0, flag_n = 1'b0, flag_v = 1'b0;
    logic [31:0] in_next_pc = '0;
    logic [31:0] in_offset = '0;
    logic        out_valid, out_taken;
    logic [31:0] out_pc;

    int checks = 0;
    int bad = 0;
    bit mon_on = 1'b0;
    bit finished = 1'b0;
    logic [31:0] last_pc = '0;

    bit          q_taken[$];
    logic [31:0] q_pc[$];
    string       q_req[$];

    always #10 clk = ~clk;

    br_resolve_unit u_br_resolve_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_index(in_index),
        .flag_z(flag_z), .flag_c(flag_c), .flag_n(flag_n), .flag_v(flag_v),
        .in_next_pc(in_next_pc), .in_offset(in_offset),
        .out_valid(out_valid), .out_taken(out_taken), .out_pc(out_pc)
    );

    function automatic bit ref_cond(input int idx, input bit z, c, n, v);
        case (idx)
            0: return z;         1: return !z;
            2: return c;         3: return !c;
            4: return n;         5: return !n;
            6: return v;         7: return !v;
            8: return c && !z;   9: return !c || z;
            10: return n == v;   11: return n != v;
            12: return !z && (n == v);
            13: return z || (n != v);
            14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string req_of(input int idx);
        if (idx < 8)  return "R2";
        if (idx < 10) return "R3";
        if (idx < 12) return "R4";
        if (idx < 14) return "R5";
        if (idx == 14) return "R6";
        return "R7";
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input int idx, input bit z, c, n, v,
                         input logic [31:0] nxt, input logic [31:0] off);
        bit t;
        @(negedge clk);
        in_valid   = 1'b1;
        in_index   = 4'(idx);
        flag_z = z; flag_c = c; flag_n = n; flag_v = v;
        in_next_pc = nxt;
        in_offset  = off;
        t = ref_cond(idx, z, c, n, v);
        q_taken.push_back(t);
        q_pc.push_back(t ? nxt + off : nxt);
        q_req.push_back(req_of(idx));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid  = 1'b0;
            in_index  = 4'd14;
            in_offset = 32'h1234_5678;
        end
    endtask

    // monitor: sample mid-high phase, after the registers settle
    always @(posedge clk) begin
        #5;
        if (mon_on) begin
            if (out_valid) begin
                if (q_pc.size() == 0) begin
                    check(1'b0, "R10", "unexpected valid", 32'(out_valid), 32'd0);
                end else begin
                    bit          et;
                    logic [31:0] ep;
                    string       er;
                    et = q_taken.pop_front();
                    ep = q_pc.pop_front();
                    er = q_req.pop_front();
                    check(out_taken == et, er, "taken", 32'(out_taken), 32'(et));
                    check(out_pc == ep, et ? "R8" : "R9", "pc", out_pc, ep);
                    last_pc = out_pc;
                end
            end else begin
                check(q_pc.size() == 0, "R11", "missing result", 32'(q_pc.size()), 32'd0);
                check(!out_taken, "R10", "taken while idle", 32'(out_taken), 32'd0);
                check(out_pc == last_pc, "R10", "pc hold", out_pc, last_pc);
            end
        end
    end

    initial begin
        #(20 * 20000);
        if (!finished) begin
            checks++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        in_valid = 1'b1;  // ignored during reset
        in_index = 4'd14;
        in_offset = 32'h40;
        repeat (3) @(posedge clk);
        #5;
        check(!out_valid, "R1", "valid in reset", 32'(out_valid), 32'd0);
        check(!out_taken, "R1", "taken in reset", 32'(out_taken), 32'd0);
        check(out_pc == 32'd0, "R1", "pc in reset", out_pc, 32'd0);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b1;
        mon_on = 1'b1;
        idle(2);

        // full sweep, back to back (R2..R7, R11)
        for (int idx = 0; idx < 16; idx++) begin
            for (int f = 0; f < 16; f++) begin
                drive(idx, f[3], f[2], f[1], f[0],
                      32'h0000_1000 + 32'(idx * 64 + f * 4),
                      32'(idx * 16 + f) - 32'd100);
            end
        end
        idle(3);

        // wrap past the top under an always-taken index (R6, R8)
        drive(14, 0, 0, 0, 0, 32'hFFFF_FFF8, 32'h0000_0010);
        // negative offset with a condition that holds (R2, R8)
        drive(0, 1, 0, 0, 0, 32'h0000_0100, 32'hFFFF_FF00);
        // same wrapping inputs, condition fails (R3, R9)
        drive(8, 1, 1, 0, 0, 32'hFFFF_FFF8, 32'h0000_0010);
        // reserved index with a large offset (R7)
        drive(15, 1, 1, 1, 1, 32'h8000_0000, 32'h7FFF_FFFF);
        idle(2);
        // isolated request between idle gaps (R10)
        drive(12, 0, 0, 1, 1, 32'h0000_2000, 32'h0000_0020);
        idle(4);

        @(negedge clk);
        check(q_pc.size() == 0, "R11", "drained", 32'(q_pc.size()), 32'd0);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule